// File: doc/BRIEF.md
# PLL Lock-Gated Clock Source Switcher

This block decides whether the system runs from an oscillator or from the main PLL output. Software may turn on the main PLL and ask for it as the clock source in the same step. The block keeps the system on the oscillator until a programmable ready time for the main PLL has counted down. It then moves the select to the PLL by itself, with no further software action.

A second, auxiliary PLL (for example one that feeds a USB controller) has its own ready timer. Its output is never gated. The block only reports when it has locked.

Each PLL has a raw lock status bit that software can poll. Status bits are cleared by writing a one to them. A masked OR of the status bits drives a single interrupt line. Disabling a PLL clears its status and restarts its timer on the next enable. If the main PLL is disabled while it is selected, the select falls back to the oscillator.

Top module: `pll_clk_switch`

## Requirements
- R1: While reset is asserted and after it is released, with no PLL enabled, `clk_use_pll`, `lock_stat` and `irq` are all 0.
- R2: Bit 0 of the per-PLL vectors is the main PLL. With `pll_en[0]` held high, `lock_stat[0]` becomes 1 exactly N+1 rising edges after the first edge that samples the enable high. N is `main_ready_cnt` sampled at that first edge.
- R3: While `sel_pll_req` is high and the main PLL has not reached its ready time, `clk_use_pll` stays 0 (oscillator). It becomes 1 at the same edge as the main lock.
- R4: With the main PLL locked, `clk_use_pll` follows `sel_pll_req` one edge later, with no other action. Dropping the request returns to the oscillator at the next edge.
- R5: Sampling `pll_en[0]` low clears `lock_stat[0]` and `clk_use_pll` at that edge. A later enable restarts the full ready count.
- R6: Bit 1 is the auxiliary PLL. `lock_stat[1]` sets after its own count, with the same timing as R2 but using `aux_ready_cnt` and `pll_en[1]`. The auxiliary PLL never affects `clk_use_pll`.
- R7: A 1 on `stat_clr[i]` clears `lock_stat[i]` at that edge. If the lock event happens at the same edge, setting wins. Clearing a status bit does not change `clk_use_pll`, and the bit does not set again until the PLL is re-enabled.
- R8: `irq` is 1 exactly when some bit i has both `lock_stat[i]` and `irq_mask[i]` set. It follows mask changes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_pll_req | input | 1 | Software asks for the main PLL as clock source |
| pll_en | input | 2 | PLL enables, bit 0 main, bit 1 auxiliary |
| main_ready_cnt | input | CNT_W | Main PLL ready count, loaded on enable |
| aux_ready_cnt | input | CNT_W | Auxiliary PLL ready count, loaded on enable |
| stat_clr | input | 2 | Write-one-to-clear strobes for the status bits |
| irq_mask | input | 2 | Interrupt enables per status bit |
| clk_use_pll | output | 1 | 1 selects the main PLL, 0 the oscillator |
| lock_stat | output | 2 | Raw lock status bits |
| irq | output | 1 | Masked OR of the status bits |

## Verification
The hardest cases to reach from the ports are those where several actions land on the same edge as a PLL's lock:
- a clear strobe at the lock edge;
- the main PLL being disabled just after it is selected;
- the request being dropped just as the lock arrives.

Random stimulus keeps the ready counts small (0 to 7) and toggles the enables only rarely, so locks happen often and clears and requests often coincide with them. Directed sequences add a zero-length count, a clear at the exact lock edge and a re-enable that must restart the count. A bench model counts edges since each enable and predicts every output each cycle.

// File: rtl/pll_sw_pkg.sv
package pll_sw_pkg;
   localparam int NUM_PLL  = 2;
   localparam int PLL_MAIN = 0;
   localparam int PLL_AUX  = 1;

   typedef enum logic {
      SRC_OSC = 1'b0,
      SRC_PLL = 1'b1
   } clk_src_e;
endpackage

// File: rtl/pll_ready_timer.sv
module pll_ready_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [CNT_W-1:0] ready_cnt,
   output logic             locked,
   output logic             lock_pulse
);
   logic             running;
   logic [CNT_W-1:0] remain;

   // The lock event is the single cycle in which the count has run out
   // but the lock flag is not yet set.
   assign lock_pulse = en && running && (remain == '0) && !locked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         remain  <= '0;
         locked  <= 1'b0;
      end else if (!en) begin
         running <= 1'b0;
         remain  <= '0;
         locked  <= 1'b0;
      end else if (!running) begin
         running <= 1'b1;
         remain  <= ready_cnt;
      end else if (remain != '0) begin
         remain <= remain - 1'b1;
      end else begin
         locked <= 1'b1;
      end
   end

   // R5
   disabled_unlocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !locked);
   // R2
   lock_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && en) |=> locked);
   // R2
   lock_needs_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(running));
endmodule

// File: rtl/pll_lock_status.sv
module pll_lock_status #(
   parameter int NUM     = 2,
   parameter bit REG_IRQ = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NUM-1:0] en,
   input  logic [NUM-1:0] lock_pulse,
   input  logic [NUM-1:0] clr,
   input  logic [NUM-1:0] mask,
   output logic [NUM-1:0] stat,
   output logic           irq
);
   for (genvar i = 0; i < NUM; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             stat[i] <= 1'b0;
         else if (!en[i])        stat[i] <= 1'b0;
         else if (lock_pulse[i]) stat[i] <= 1'b1;
         else if (clr[i])        stat[i] <= 1'b0;
      end

      // R7
      stat_sets_on_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(stat[i]) |-> $past(lock_pulse[i]));
      // R5
      stat_clears_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !en[i] |=> !stat[i]);
   end

   logic irq_comb;
   assign irq_comb = |(stat & mask);

   if (REG_IRQ) begin : g_irq_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= irq_comb;
      end
   end else begin : g_irq_comb
      assign irq = irq_comb;
      // R8
      irq_needs_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
         irq |-> (stat != '0));
   end
endmodule

// File: rtl/pll_src_select.sv
module pll_src_select
   import pll_sw_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic sel_req,
   input  logic main_en,
   input  logic main_locked,
   input  logic main_pulse,
   output logic use_pll
);
   clk_src_e src_q;
   clk_src_e src_d;

   always_comb begin
      src_d = SRC_OSC;
      if (sel_req && main_en && (main_locked || main_pulse)) src_d = SRC_PLL;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src_q <= SRC_OSC;
      else        src_q <= src_d;
   end

   assign use_pll = (src_q == SRC_PLL);

   // R3
   pll_only_when_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      use_pll |-> main_locked);
   // R4
   pll_only_on_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
      use_pll |-> $past(sel_req));
   // R5
   fallback_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !main_en |=> !use_pll);
endmodule

// File: rtl/pll_clk_switch.sv
module pll_clk_switch
   import pll_sw_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter bit REG_IRQ = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_pll_req,
   input  logic [1:0]       pll_en,
   input  logic [CNT_W-1:0] main_ready_cnt,
   input  logic [CNT_W-1:0] aux_ready_cnt,
   input  logic [1:0]       stat_clr,
   input  logic [1:0]       irq_mask,
   output logic             clk_use_pll,
   output logic [1:0]       lock_stat,
   output logic             irq
);
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt_w
      $error("pll_clk_switch: CNT_W must lie in 1..32");
   end

   logic [NUM_PLL-1:0][CNT_W-1:0] ready_vec;
   logic [NUM_PLL-1:0]            locked;
   logic [NUM_PLL-1:0]            pulse;

   assign ready_vec[PLL_MAIN] = main_ready_cnt;
   assign ready_vec[PLL_AUX]  = aux_ready_cnt;

   for (genvar i = 0; i < NUM_PLL; i++) begin : g_timer
      pll_ready_timer #(.CNT_W(CNT_W)) timer_i (
         .clk        (clk),
         .rst_n      (rst_n),
         .en         (pll_en[i]),
         .ready_cnt  (ready_vec[i]),
         .locked     (locked[i]),
         .lock_pulse (pulse[i])
      );
   end

   pll_lock_status #(.NUM(NUM_PLL), .REG_IRQ(REG_IRQ)) status_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (pll_en),
      .lock_pulse (pulse),
      .clr        (stat_clr),
      .mask       (irq_mask),
      .stat       (lock_stat),
      .irq        (irq)
   );

   pll_src_select select_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .sel_req     (sel_pll_req),
      .main_en     (pll_en[PLL_MAIN]),
      .main_locked (locked[PLL_MAIN]),
      .main_pulse  (pulse[PLL_MAIN]),
      .use_pll     (clk_use_pll)
   );

   // R6
   aux_no_select_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_use_pll != $past(clk_use_pll)) |->
         ($past(sel_pll_req) != $past(sel_pll_req, 2) || $past(pll_en[0]) != $past(pll_en[0], 2)
          || $past(locked[PLL_MAIN]) != $past(locked[PLL_MAIN], 2) || $past(pulse[PLL_MAIN])
          || $past(!rst_n, 2)));
endmodule

// File: tb/pll_clk_switch_tb_top.sv
module pll_clk_switch_tb_top;
   localparam int CNT_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             sel_pll_req = 1'b0;
   logic [1:0]       pll_en = '0;
   logic [CNT_W-1:0] main_ready_cnt = '0;
   logic [CNT_W-1:0] aux_ready_cnt = '0;
   logic [1:0]       stat_clr = '0;
   logic [1:0]       irq_mask = '0;
   logic             clk_use_pll;
   logic [1:0]       lock_stat;
   logic             irq;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   pll_clk_switch #(.CNT_W(CNT_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .sel_pll_req(sel_pll_req), .pll_en(pll_en),
      .main_ready_cnt(main_ready_cnt), .aux_ready_cnt(aux_ready_cnt),
      .stat_clr(stat_clr), .irq_mask(irq_mask),
      .clk_use_pll(clk_use_pll), .lock_stat(lock_stat), .irq(irq));

   // Reference model: counts edges since each enable.
   int   m_edges [2];
   int   m_need  [2];
   bit   m_lock  [2];
   bit   m_stat  [2];
   bit   m_use;

   function automatic bit lock_after(int edges, int need);
      return edges >= need + 2;
   endfunction

   function automatic bit exp_irq(bit s0, bit s1, logic [1:0] m);
      return (s0 && m[0]) || (s1 && m[1]);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 2; i++) begin
            m_edges[i] = 0; m_need[i] = 0; m_lock[i] = 0; m_stat[i] = 0;
         end
         m_use = 0;
      end else begin
         for (int i = 0; i < 2; i++) begin
            if (!pll_en[i]) begin
               m_edges[i] = 0; m_lock[i] = 0; m_stat[i] = 0;
            end else begin
               bit nl;
               if (m_edges[i] == 0) m_need[i] = (i == 0) ? int'(main_ready_cnt) : int'(aux_ready_cnt);
               if (m_edges[i] < 100000) m_edges[i]++;
               nl = lock_after(m_edges[i], m_need[i]);
               if (nl && !m_lock[i]) m_stat[i] = 1;
               else if (stat_clr[i]) m_stat[i] = 0;
               m_lock[i] = nl;
            end
         end
         m_use = sel_pll_req && pll_en[0] && m_lock[0];
      end
   end

   task automatic check_eq(string tag, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Compare every output with the model; called away from the rising edge.
   task automatic compare_all(string tag_sel, string tag_main, string tag_aux);
      check_eq(tag_sel,  clk_use_pll, m_use);
      check_eq(tag_main, lock_stat[0], m_stat[0]);
      check_eq(tag_aux,  lock_stat[1], m_stat[1]);
      check_eq("R8 irq", irq, exp_irq(m_stat[0], m_stat[1], irq_mask));
   endtask

   task automatic step(string ts, string tm, string ta);
      @(posedge clk);
      @(negedge clk);
      compare_all(ts, tm, ta);
   endtask

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      // R1 reset state
      check_eq("R1 use_pll", clk_use_pll, 0);
      check_eq("R1 stat", lock_stat, 0);
      check_eq("R1 irq", irq, 0);
      rst_n = 1'b1;
      step("R1", "R1", "R1");

      // R2/R3: enable and request in one step, count 5
      main_ready_cnt = 16'd5; sel_pll_req = 1'b1; pll_en[0] = 1'b1; irq_mask = 2'b01;
      for (int k = 0; k < 6; k++) begin
         step("R3 held on osc", "R2 main lock", "R6");
         check_eq("R3 select before lock", clk_use_pll, 0);
      end
      step("R3 switch at lock", "R2 main lock", "R6");
      check_eq("R2 lock at N+1", lock_stat[0], 1);
      check_eq("R3 pll selected", clk_use_pll, 1);
      check_eq("R8 irq masked in", irq, 1);
      irq_mask = 2'b00;
      #1 check_eq("R8 irq masked out", irq, 0);

      // R7: clear status, select unaffected
      stat_clr = 2'b01;
      step("R7", "R7 clear", "R6");
      stat_clr = 2'b00;
      check_eq("R7 cleared", lock_stat[0], 0);
      check_eq("R7 select kept", clk_use_pll, 1);
      step("R7", "R7 no reset", "R6");

      // R4: drop request, then ask again
      sel_pll_req = 1'b0;
      step("R4 drop", "R4", "R6");
      check_eq("R4 back to osc", clk_use_pll, 0);
      sel_pll_req = 1'b1;
      step("R4 reselect", "R4", "R6");
      check_eq("R4 reselected", clk_use_pll, 1);

      // R6: aux lock with count 0, no effect on select
      aux_ready_cnt = 16'd0; pll_en[1] = 1'b1; sel_pll_req = 1'b0;
      step("R6", "R6", "R6 aux");
      step("R6", "R6", "R6 aux");
      check_eq("R6 aux lock", lock_stat[1], 1);
      check_eq("R6 no select", clk_use_pll, 0);

      // R5: disable main while selected, re-enable restarts
      sel_pll_req = 1'b1;
      step("R5", "R5", "R6");
      pll_en[0] = 1'b0;
      step("R5 fallback", "R5 clear", "R6");
      check_eq("R5 fallback", clk_use_pll, 0);
      main_ready_cnt = 16'd3; pll_en[0] = 1'b1;
      for (int k = 0; k < 4; k++) step("R5 restart", "R5 restart", "R6");
      check_eq("R5 not yet", lock_stat[0], 0);
      // clear at the exact lock edge: set wins (R7)
      stat_clr = 2'b01;
      step("R5", "R7 set wins", "R6");
      stat_clr = 2'b00;
      check_eq("R7 set wins", lock_stat[0], 1);

      // Random phase
      for (int c = 0; c < 4000; c++) begin
         if ($urandom_range(15) == 0) pll_en[0] = ~pll_en[0];
         if ($urandom_range(15) == 0) pll_en[1] = ~pll_en[1];
         if ($urandom_range(7) == 0)  sel_pll_req = ~sel_pll_req;
         main_ready_cnt = CNT_W'($urandom_range(7));
         aux_ready_cnt  = CNT_W'($urandom_range(7));
         stat_clr = ($urandom_range(3) == 0) ? 2'($urandom_range(3)) : 2'b00;
         irq_mask = 2'($urandom_range(3));
         step("R3 rand", "R2 rand", "R6 rand");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule